// File: doc/BRIEF.md
# Channel Mapping Priority Resolver

This block sits behind the pending/enable stage of an interrupt controller. Every cycle it takes the vector of enabled, pending system interrupts. Each source is assigned to one of 32 channels through programmable mapping bytes. The channel number sets the source's priority, and a lower channel number beats a higher one.

Channels 0 and 1 feed the fast host line. Channels 2 to 31 feed the normal host line. For each host the block chooses a winner and reports three things: its source index, its channel and a valid flag. A host line is asserted only when it has a winner, its host-enable bit is set and the global enable is set.

Configuration arrives as single-cycle register writes on a simple write port. Software sets the global enable, sets or clears the host-enable bits by host index, and writes the packed channel-map words.

Top module: `intc_chan_resolver`

## Requirements
- R1: The channel map is held in 32-bit words at write address 0x10+i. Source k uses word k/4, byte k%4, and only bits [8*(k%4)+4 : 8*(k%4)] hold its channel, so the upper 3 bits of each byte are ignored. Every channel resets to 0.
- R2: For each host, the winning source is the eligible pending source with the lowest channel number.
- R3: When several eligible pending sources share the winning channel, the lowest-numbered source wins.
- R4: Sources on channels 0 and 1 compete only for host 0, the fast line (bit 0 of each per-host output). Sources on channels 2 to 31 compete only for host 1, the normal line (bit 1).
- R5: A write to address 0x01 sets the host-enable bit of the host whose index is in wr_data_i. A write to address 0x02 clears that bit. Both bits reset to 0, and a cleared bit holds that host line low.
- R6: The global enable is bit 0 of address 0x00 and resets to 0. While it is 0, both host lines stay low.
- R7: host_vld_o[h], host_src_o and host_chan_o report the winner of host h whatever the enables are. When host h has no eligible pending source, its valid bit is 0 and its source and channel fields are 0.
- R8: All outputs are registered. A change on pend_i shows at the outputs after the next rising clock edge. A configuration write takes effect at its edge, and its effect shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_SRC | Enabled-pending system interrupt vector |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| host_irq_o | output | 2 | Host lines: bit 0 is fast, bit 1 is normal |
| host_vld_o | output | 2 | Per-host winner valid |
| host_src_o | output | 2*SRC_W | Per-host winning source, host h in bits [h*SRC_W +: SRC_W] |
| host_chan_o | output | 10 | Per-host winning channel, host h in bits [h*5 +: 5] |

## Verification
The bench first runs with the map at reset. In that state every source sits on channel 0, so the fast host must pick the lowest pending source and the normal host must stay idle.

It then uses directed maps to separate the different rules:
- two normal-line sources on different channels, which shows that channel number, not source index, decides the winner;
- two sources on one channel, which shows the source tie-break;
- fast and normal sources pending together, which shows that the two hosts resolve separately;
- a byte with junk in its upper bits, which shows that those bits are masked.

Toggling the global and host enables while sources stay pending shows that gating reaches only the lines, not the reported winner. Random maps and pending vectors, checked against an independent model, cover the remaining combinations.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CH_W      = 5;
  localparam int N_HOST    = 2;
  localparam int N_FAST_CH = 2;
  localparam int AW        = 6;
  localparam int DW        = 32;
  localparam logic [AW-1:0] A_GLB      = 6'h00;
  localparam logic [AW-1:0] A_HEN_SET  = 6'h01;
  localparam logic [AW-1:0] A_HEN_CLR  = 6'h02;
  localparam int            MAP_BASE   = 16;
  localparam int            HOST_FAST  = 0;
  localparam int            HOST_NORM  = 1;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  output logic [N_SRC*CH_W-1:0] chan_map_o,
  output logic [N_HOST-1:0]     hen_o,
  output logic                  glb_o
);
  localparam int HIDX_W = $clog2(N_HOST);

  logic [N_HOST-1:0] hen_q;
  logic              glb_q;
  logic [HIDX_W-1:0] hidx;

  assign hidx = wr_data_i[HIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q <= 1'b0;
      hen_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_GLB) glb_q <= wr_data_i[0];
      // index outside host range is dropped
      if (wr_addr_i == A_HEN_SET && wr_data_i < DW'(N_HOST)) hen_q[hidx] <= 1'b1;
      if (wr_addr_i == A_HEN_CLR && wr_data_i < DW'(N_HOST)) hen_q[hidx] <= 1'b0;
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_map
    logic [CH_W-1:0] ch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ch_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(MAP_BASE + k / 4))
        ch_q <= wr_data_i[8*(k%4) +: CH_W];
    end
    assign chan_map_o[k*CH_W +: CH_W] = ch_q;
  end

  assign hen_o = hen_q;
  assign glb_o = glb_q;
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
  import intc_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter bit IS_FAST = 1'b1,
  localparam int SRC_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]      pend_i,
  input  logic [N_SRC*CH_W-1:0] chan_map_i,
  output logic                  found_o,
  output logic [SRC_W-1:0]      src_o,
  output logic [CH_W-1:0]       chan_o
);
  localparam logic [CH_W-1:0] FAST_LIM = CH_W'(N_FAST_CH);

  always_comb begin
    found_o = 1'b0;
    src_o   = '0;
    chan_o  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      logic [CH_W-1:0] ch;
      logic            elig;
      ch   = chan_map_i[i*CH_W +: CH_W];
      elig = pend_i[i] && (IS_FAST ? (ch < FAST_LIM) : (ch >= FAST_LIM));
      // strict compare keeps the lower source on a tie
      if (elig && (!found_o || ch < chan_o)) begin
        found_o = 1'b1;
        src_o   = SRC_W'(i);
        chan_o  = ch;
      end
    end
  end
endmodule

// File: rtl/intc_chan_resolver.sv
module intc_chan_resolver
  import intc_pkg::*;
#(
  parameter int N_SRC  = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic [N_HOST-1:0]       host_irq_o,
  output logic [N_HOST-1:0]       host_vld_o,
  output logic [N_HOST*SRC_W-1:0] host_src_o,
  output logic [N_HOST*CH_W-1:0]  host_chan_o
);
  logic [N_SRC*CH_W-1:0]  chan_map;
  logic [N_HOST-1:0]      hen_q;
  logic                   glb_q;
  logic [N_HOST-1:0]      found;
  logic [N_HOST*SRC_W-1:0] src_d;
  logic [N_HOST*CH_W-1:0]  chan_d;

  intc_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .chan_map_o (chan_map),
    .hen_o      (hen_q),
    .glb_o      (glb_q)
  );

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    intc_prio_pick #(.N_SRC(N_SRC), .IS_FAST(h == HOST_FAST)) u_pick (
      .pend_i     (pend_i),
      .chan_map_i (chan_map),
      .found_o    (found[h]),
      .src_o      (src_d[h*SRC_W +: SRC_W]),
      .chan_o     (chan_d[h*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_irq_o  <= '0;
      host_vld_o  <= '0;
      host_src_o  <= '0;
      host_chan_o <= '0;
    end else begin
      host_irq_o  <= found & hen_q & {N_HOST{glb_q}};
      host_vld_o  <= found;
      host_src_o  <= src_d;
      host_chan_o <= chan_d;
    end
  end
endmodule

// File: rtl/intc_chan_resolver_chk.sv
module intc_chan_resolver_chk
  import intc_pkg::*;
#(
  parameter int N_SRC  = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        pend_i,
  input logic [N_HOST-1:0]       host_irq_o,
  input logic [N_HOST-1:0]       host_vld_o,
  input logic [N_HOST*SRC_W-1:0] host_src_o,
  input logic [N_HOST*CH_W-1:0]  host_chan_o,
  input logic [N_HOST-1:0]       hen_q,
  input logic                    glb_q
);
  logic [N_SRC-1:0] pend_d;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_d <= '0;
    else         pend_d <= pend_i;

  a_r6_line_needs_glb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o != '0) |-> $past(glb_q));
  a_r5_fast_needs_hen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o[HOST_FAST] |-> $past(hen_q[HOST_FAST]));
  a_r5_norm_needs_hen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o[HOST_NORM] |-> $past(hen_q[HOST_NORM]));
  a_r4_fast_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_vld_o[HOST_FAST] |-> host_chan_o[HOST_FAST*CH_W +: CH_W] < CH_W'(N_FAST_CH));
  a_r4_norm_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_vld_o[HOST_NORM] |-> host_chan_o[HOST_NORM*CH_W +: CH_W] >= CH_W'(N_FAST_CH));
  a_r7_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_d == '0) |-> (host_vld_o == '0));
  a_r7_fast_src_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_vld_o[HOST_FAST] |-> pend_d[host_src_o[HOST_FAST*SRC_W +: SRC_W]]);
  a_r7_norm_src_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_vld_o[HOST_NORM] |-> pend_d[host_src_o[HOST_NORM*SRC_W +: SRC_W]]);
endmodule

bind intc_chan_resolver intc_chan_resolver_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend_i      (pend_i),
  .host_irq_o  (host_irq_o),
  .host_vld_o  (host_vld_o),
  .host_src_o  (host_src_o),
  .host_chan_o (host_chan_o),
  .hen_q       (hen_q),
  .glb_q       (glb_q)
);

// File: tb/tb_intc_chan_resolver.sv
module tb_intc_chan_resolver;
  localparam int N_SRC = 16;
  localparam int SW    = 4;

  typedef struct {
    logic [1:0]   irq;
    logic [1:0]   vld;
    logic [SW-1:0] src0, src1;
    logic [4:0]   ch0, ch1;
    string        req;
  } exp_t;

  logic            clk_i = 0, rst_ni = 0;
  logic [N_SRC-1:0] pend_i = '0;
  logic            wr_en_i = 0;
  logic [5:0]      wr_addr_i = '0;
  logic [31:0]     wr_data_i = '0;
  logic [1:0]      host_irq_o, host_vld_o;
  logic [2*SW-1:0] host_src_o;
  logic [9:0]      host_chan_o;

  intc_chan_resolver #(.N_SRC(N_SRC)) dut (.*);

  always #10 clk_i = ~clk_i;

  int   errors = 0, checks = 0;
  exp_t q[$];
  logic [4:0] bmap[N_SRC];
  logic       bglb = 0;
  logic [1:0] bhen = 0;
  bit         done = 0;

  function automatic exp_t model(logic [N_SRC-1:0] p, string req);
    exp_t e;
    e.vld = 0; e.src0 = 0; e.src1 = 0; e.ch0 = 0; e.ch1 = 0; e.req = req;
    for (int i = 0; i < N_SRC; i++) begin
      if (!p[i]) continue;
      if (bmap[i] < 2) begin
        if (!e.vld[0] || bmap[i] < e.ch0) begin e.vld[0] = 1; e.ch0 = bmap[i]; e.src0 = SW'(i); end
      end else begin
        if (!e.vld[1] || bmap[i] < e.ch1) begin e.vld[1] = 1; e.ch1 = bmap[i]; e.src1 = SW'(i); end
      end
    end
    e.irq = e.vld & bhen & {2{bglb}};
    return e;
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 0;
    if (a == 6'h00) bglb = d[0];
    if (a == 6'h01 && d < 2) bhen[d[0]] = 1;
    if (a == 6'h02 && d < 2) bhen[d[0]] = 0;
    if (a >= 6'h10 && a < 6'h10 + N_SRC/4)
      for (int j = 0; j < 4; j++) bmap[(a-6'h10)*4+j] = d[8*j +: 5];
  endtask

  task automatic apply(logic [N_SRC-1:0] p, string req);
    @(negedge clk_i);
    pend_i = p;
    @(posedge clk_i);
    q.push_back(model(p, req));
  endtask

  task automatic cmp(exp_t e);
    checks++;
    if (host_irq_o !== e.irq || host_vld_o !== e.vld ||
        host_src_o !== {e.src1, e.src0} || host_chan_o !== {e.ch1, e.ch0}) begin
      errors++;
      $display("FAIL %s: irq=%b vld=%b src=%h ch=%h exp irq=%b vld=%b src=%h ch=%h",
               e.req, host_irq_o, host_vld_o, host_src_o, host_chan_o,
               e.irq, e.vld, {e.src1, e.src0}, {e.ch1, e.ch0});
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    if (q.size() > 0) cmp(q.pop_front());
  end

  initial begin
    for (int i = 0; i < N_SRC; i++) bmap[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    begin exp_t z = model('0, "R7 reset outputs"); cmp(z); end
    // R1 reset map: all on channel 0, fast host picks lowest source
    apply(16'h0A40, "R1 R3 reset map lowest source");
    apply(16'h0000, "R7 idle no valid");
    wr(6'h00, 1); wr(6'h01, 0); wr(6'h01, 1);
    apply(16'h8001, "R6 R5 lines enabled");
    // R2: src3 ch5, src7 ch2 -> src7
    wr(6'h10, 32'h0500_0000); wr(6'h11, 32'h0200_0000);
    apply(16'h0088, "R2 lowest channel wins");
    // R3: src4 and src6 both ch6
    wr(6'h11, 32'h0006_0006);
    apply(16'h0050, "R3 tie lowest source");
    // R4: fast + normal together, src9 ch1, src8 ch0
    wr(6'h12, 32'h0000_0100);
    apply(16'h0350, "R4 both hosts resolve");
    // R1 upper bits masked: byte E3 -> ch3 at src 12
    wr(6'h13, 32'h0000_00E3);
    apply(16'h1000, "R1 upper bits ignored");
    // R6 global off
    wr(6'h00, 0);
    apply(16'h1300, "R6 global gate");
    wr(6'h00, 1); wr(6'h02, 0);
    apply(16'h1300, "R5 fast host cleared");
    wr(6'h02, 1); wr(6'h01, 0);
    apply(16'h1300, "R5 normal host cleared");
    wr(6'h01, 1);
    // R8: latency, consecutive changes
    apply(16'h0001, "R8 latency step a");
    apply(16'h1000, "R8 latency step b");
    apply(16'h0000, "R8 latency step c");
    for (int r = 0; r < 60; r++) begin
      if (r % 6 == 0) wr(6'(6'h10 + $urandom_range(0, 3)), $urandom());
      apply(N_SRC'($urandom()), "R2 R3 R4 random");
    end
    @(negedge clk_i); @(negedge clk_i);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk_i); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule